// File: doc/BRIEF.md
# Reduced-Rate Audio Frame Strobe

The block turns a full-rate frame sync into a slower audio frame rate. It divides the one-cycle full-rate sync pulse by a ratio of 2^code, where the 3-bit code selects a ratio from 1 to 128. It marks each full-rate frame that carries a fresh reduced-rate sample, so a local processor can track that frame. Each instance holds its own code, so different instances can run at different reduced rates.

A strobe pin carries the reduced-rate phase and can work in either direction. When it is an output, the block drives the pin high during the frame that holds a new sample. When it is an input, a rising edge from outside pulls the divider phase back to zero at the next sync, so the local rate locks to an external source. All pins are plain control and status lines with no handshake. A full-rate frame is the interval that starts in the cycle after one sync pulse and ends in the cycle of the next sync pulse. Its count is the divider count held during that interval.

Top module: `rr_frame_strobe`

## Requirements
- R1: While enabled and not realigned, the count of the k-th sync after enable equals k mod 2^code. Code 0 gives ratio 1, and code 7 gives ratio 128.
- R2: `rr_pulse_o` is high for one cycle, in the cycle after each sync that starts a frame with count zero. It is low in every other cycle.
- R3: `new_smp_o` is high for the whole of each enabled frame with count zero and low during every other frame. It changes only in the cycle after a sync or when the enable changes.
- R4: In output mode (`strb_dir_i` = 1) with the enable high, `strb_oe_o` is 1 and `strb_o` equals `new_smp_o`. The strobe is therefore high for exactly one full-rate frame in every 2^code frames.
- R5: In input mode (`strb_dir_i` = 0), `strb_oe_o` and `strb_o` are both 0.
- R6: In input mode, a rising edge on `strb_in_i` forces the count to zero at the next sync. An edge in the same cycle as a sync acts at that sync. The counting from R1 then continues from the new phase. A level held high causes no further realign, and edges in output mode have no effect.
- R7: A change of `ratio_code_i` while counting takes effect only when the count wraps to zero (or is realigned). The period in progress finishes at the old ratio.
- R8: With the enable low, `strb_o`, `strb_oe_o`, `new_smp_o` and `rr_pulse_o` are 0, syncs are ignored and the count is held at zero. After the enable rises, the current frame has count zero and the first sync moves the count to 1 mod 2^code.
- R9: After reset, the count is zero, no strobe edge is pending and `rr_pulse_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | One-cycle full-rate frame sync pulse |
| ratio_code_i | input | 3 | log2 of the division ratio |
| en_i | input | 1 | Block enable |
| strb_dir_i | input | 1 | Strobe direction: 1 drives out, 0 listens |
| strb_in_i | input | 1 | Strobe pin input value |
| rr_pulse_o | output | 1 | One-cycle reduced-rate frame pulse |
| strb_o | output | 1 | Strobe pin output value |
| strb_oe_o | output | 1 | Strobe pin output enable |
| new_smp_o | output | 1 | High during the frame with a new reduced-rate sample |

## Verification
The assertions assume that `sync_i` is a single-cycle pulse and that the enable changes between syncs rather than in a sync cycle. They also assume the strobe input is already synchronous to `clk`. The stimulus follows these rules: it raises sync for one negedge-to-negedge interval with idle cycles on each side, and it changes the enable, direction and strobe input only at negedges. Every ratio code is swept in output mode over two full periods, and separate cases cover a mid-period code change, realign with the edge before the sync and in the same cycle as the sync, a held strobe level, and a disable in mid-period.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned RR_CODE_W = 3;

  typedef enum logic {
    STRB_LISTEN = 1'b0,
    STRB_DRIVE  = 1'b1
  } strb_dir_e;
endpackage

// File: rtl/rr_edge_catch.sv
module rr_edge_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic sync_i,
  input  logic strb_in_i,
  output logic realign_o
);
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise      = strb_in_i & ~prev_q;
  assign realign_o = arm_i & (pend_q | rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= strb_in_i;
      if (!arm_i) pend_q <= 1'b0;
      else        pend_q <= (pend_q | rise) & ~sync_i;
    end
  end
endmodule

// File: rtl/rr_divider.sv
module rr_divider #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic              realign_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              cnt_zero_o,
  output logic              wrap_pulse_o
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  lim;
  logic              restart;

  assign lim        = ~({CNT_W{1'b1}} << code_q);
  assign restart    = realign_i | (cnt_q == lim);
  assign cnt_zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      code_q       <= '0;
      wrap_pulse_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q        <= '0;
      code_q       <= code_i;
      wrap_pulse_o <= 1'b0;
    end else begin
      wrap_pulse_o <= sync_i & restart;
      if (sync_i) begin
        if (restart) begin
          cnt_q  <= '0;
          code_q <= code_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rr_pin_ctl.sv
module rr_pin_ctl
  import rr_pkg::*;
(
  input  logic      en_i,
  input  strb_dir_e dir_i,
  input  logic      cnt_zero_i,
  output logic      strb_o,
  output logic      strb_oe_o,
  output logic      new_smp_o
);
  always_comb begin
    new_smp_o = en_i & cnt_zero_i;
    strb_oe_o = en_i & (dir_i == STRB_DRIVE);
    strb_o    = strb_oe_o & new_smp_o;
  end
endmodule

// File: rtl/rr_frame_strobe.sv
module rr_frame_strobe
  import rr_pkg::*;
#(
  parameter int unsigned CODE_W = RR_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              en_i,
  input  logic              strb_dir_i,
  input  logic              strb_in_i,
  output logic              rr_pulse_o,
  output logic              strb_o,
  output logic              strb_oe_o,
  output logic              new_smp_o
);
  strb_dir_e dir;
  logic      arm;
  logic      realign;
  logic      cnt_zero;

  assign dir = strb_dir_e'(strb_dir_i);
  assign arm = en_i & (dir == STRB_LISTEN);

  rr_edge_catch u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm),
    .sync_i    (sync_i),
    .strb_in_i (strb_in_i),
    .realign_o (realign)
  );

  rr_divider #(.CODE_W(CODE_W)) u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .sync_i       (sync_i),
    .realign_i    (realign),
    .code_i       (ratio_code_i),
    .cnt_zero_o   (cnt_zero),
    .wrap_pulse_o (rr_pulse_o)
  );

  rr_pin_ctl u_pin (
    .en_i       (en_i),
    .dir_i      (dir),
    .cnt_zero_i (cnt_zero),
    .strb_o     (strb_o),
    .strb_oe_o  (strb_oe_o),
    .new_smp_o  (new_smp_o)
  );
endmodule

// File: rtl/rr_frame_strobe_chk.sv
module rr_frame_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_i,
  input logic en_i,
  input logic strb_dir_i,
  input logic rr_pulse_o,
  input logic strb_o,
  input logic strb_oe_o,
  input logic new_smp_o
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assert_pulse_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rr_pulse_o) |-> $past(sync_i));

  assert_pulse_marks_new_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_pulse_o && en_i) |-> new_smp_o);

  assert_new_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(sync_i) && $stable(en_i)) |-> $stable(new_smp_o));

  assert_no_drive_unless_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_oe_o |-> !strb_o);

  assert_listen_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_dir_i |-> !strb_oe_o);

  assert_enable_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $rose(en_i)) |-> new_smp_o);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !en_i && !$past(en_i)) |-> (!rr_pulse_o && !new_smp_o && !strb_oe_o));
endmodule

bind rr_frame_strobe rr_frame_strobe_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_i     (sync_i),
  .en_i       (en_i),
  .strb_dir_i (strb_dir_i),
  .rr_pulse_o (rr_pulse_o),
  .strb_o     (strb_o),
  .strb_oe_o  (strb_oe_o),
  .new_smp_o  (new_smp_o)
);

// File: tb/tb_rr_frame_strobe.sv
`timescale 1ns/1ps
module tb_rr_frame_strobe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_i = 1'b0;
  logic [2:0] ratio_code_i = 3'd0;
  logic       en_i = 1'b0;
  logic       strb_dir_i = 1'b1;
  logic       strb_in_i = 1'b0;
  logic       rr_pulse_o, strb_o, strb_oe_o, new_smp_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rr_frame_strobe dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ratio_code_i(ratio_code_i),
    .en_i(en_i), .strb_dir_i(strb_dir_i), .strb_in_i(strb_in_i),
    .rr_pulse_o(rr_pulse_o), .strb_o(strb_o), .strb_oe_o(strb_oe_o),
    .new_smp_o(new_smp_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_sync();
    @(negedge clk) sync_i = 1'b1;
    @(negedge clk) sync_i = 1'b0;
  endtask

  task automatic check_frame(input string req, input int exp, input bit drive);
    check(req, "new_smp", new_smp_o, exp);
    check("R4/R5", "strb_oe", strb_oe_o, drive ? 1 : 0);
    check("R4/R5", "strb", strb_o, drive ? exp : 0);
  endtask

  // Runs n syncs; k counts syncs since the current phase zero.
  task automatic run_syncs(input string req, input int n, input int ratio,
                           input int k0, input bit drive);
    for (int i = 1; i <= n; i++) begin
      int k = k0 + i;
      int exp = ((k % ratio) == 0) ? 1 : 0;
      do_sync();
      check(req, "rr_pulse", rr_pulse_o, exp);
      check_frame(req, exp, drive);
      @(negedge clk);
      check("R2", "rr_pulse gap", rr_pulse_o, 0);
      check("R3", "new_smp hold", new_smp_o, exp);
    end
  endtask

  task automatic start(input int code, input bit drive);
    @(negedge clk);
    en_i = 1'b0; ratio_code_i = 3'(code); strb_dir_i = drive;
    @(negedge clk);
    en_i = 1'b1;
    #1;
    check("R8", "new_smp at enable", new_smp_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "rr_pulse in reset", rr_pulse_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "rr_pulse after reset", rr_pulse_o, 0);
    check("R8", "new_smp disabled", new_smp_o, 0);
    check("R8", "strb_oe disabled", strb_oe_o, 0);
    check("R8", "strb disabled", strb_o, 0);

    // R1 sweep of every code in output mode
    for (int c = 0; c < 8; c++) begin
      start(c, 1'b1);
      run_syncs("R1", 2 * (1 << c) + 3, 1 << c, 0, 1'b1);
    end

    // R7: code change mid-period, ratio 4 -> 2 applied at wrap (sync 4)
    start(2, 1'b1);
    run_syncs("R7", 1, 4, 0, 1'b1);
    ratio_code_i = 3'd1;
    run_syncs("R7", 3, 4, 1, 1'b1);
    run_syncs("R7", 4, 2, 0, 1'b1);

    // R6: strobe edge in output mode is ignored
    start(3, 1'b1);
    run_syncs("R6", 2, 8, 0, 1'b1);
    @(negedge clk) strb_in_i = 1'b1;
    @(negedge clk) strb_in_i = 1'b0;
    run_syncs("R6", 7, 8, 2, 1'b1);

    // R5/R6: input mode, edge between syncs realigns at next sync
    start(3, 1'b0);
    run_syncs("R5", 3, 8, 0, 1'b0);
    @(negedge clk) strb_in_i = 1'b1;
    run_syncs("R6", 1, 8, -1, 1'b0);
    // level held high: no further realign
    run_syncs("R6", 10, 8, 0, 1'b0);
    @(negedge clk) strb_in_i = 1'b0;
    // count is 10 mod 8 = 2; edge in the sync cycle acts at that sync
    @(negedge clk);
    strb_in_i = 1'b1; sync_i = 1'b1;
    @(negedge clk) sync_i = 1'b0;
    check("R6", "same-cycle realign pulse", rr_pulse_o, 1);
    check_frame("R6", 1, 1'b0);
    @(negedge clk) strb_in_i = 1'b0;
    run_syncs("R6", 9, 8, 0, 1'b0);

    // R8: disable mid-period, syncs ignored, restart at phase zero
    start(2, 1'b1);
    run_syncs("R8", 2, 4, 0, 1'b1);
    @(negedge clk) en_i = 1'b0;
    #1;
    check("R8", "new_smp off", new_smp_o, 0);
    check("R8", "strb_oe off", strb_oe_o, 0);
    check("R8", "strb off", strb_o, 0);
    do_sync();
    check("R8", "rr_pulse while off", rr_pulse_o, 0);
    check("R8", "new_smp while off", new_smp_o, 0);
    @(negedge clk) en_i = 1'b1;
    #1;
    check("R8", "new_smp re-enable", new_smp_o, 1);
    run_syncs("R8", 5, 4, 0, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule